// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

A small bank of one-bit ownership tokens shared between a left and a right requester. Each requester reaches the bank through its own token-select strobe, which is separate from any memory enable, so token traffic never touches a storage array. A requester asks for a token by writing 0 to it. It then reads the token back: a 0 means it now holds the token, a 1 means it does not. Writing 1 gives the token up.

Each token has at most one owner at any time. A request that finds the token taken is remembered. When the owner gives the token up, the waiting requester receives it on that same clock edge. If both requesters ask for a free token in the same cycle, the left one wins and the right one is left waiting. A requester that writes 1 to a token it does not own changes no ownership, and only withdraws its own waiting request. Read data is registered: it appears one cycle after the read access, shows the token state from before any write in that cycle, and holds until the port's next read.

Top module: `semtok_bank`

## Requirements
- R1: After reset every token is free, no request is waiting, and both read-data outputs are 1.
- R2: A read access returns 0 only to the port that owns the addressed token. The other port, and either port on a free token, gets 1. The value shows on the read-data output one cycle after the access, reflects ownership before any write in that cycle, and holds until that port's next read.
- R3: When a port's select is low, its write-enable, index and data inputs are ignored: no ownership change and no update of its read data.
- R4: With write-enable high and data 0, a port requesting a free token becomes its owner at that clock edge.
- R5: A request for a token owned by the other port does not change ownership. The request stays waiting.
- R6: When both ports request the same free token in the same cycle, the left port becomes owner and the right request stays waiting.
- R7: With write-enable high and data 1, the owner releases the token. If the other port is waiting, it becomes owner at the same edge; otherwise the token becomes free.
- R8: A write of 1 by a port that does not own the token leaves ownership unchanged and cancels that port's waiting request.
- R9: Tokens are independent and are selected by the index (token k at index k). An owner that requests its own token again keeps it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lSel | input | 1 | Left token-select strobe |
| lWrEn | input | 1 | Left write enable (1 write, 0 read) |
| lIdx | input | IDX_W | Left token index |
| lWrBit | input | 1 | Left write data (0 request, 1 release) |
| lRdBit | output | 1 | Left registered read data (0 = owned) |
| rSel | input | 1 | Right token-select strobe |
| rWrEn | input | 1 | Right write enable (1 write, 0 read) |
| rIdx | input | IDX_W | Right token index |
| rWrBit | input | 1 | Right write data (0 request, 1 release) |
| rRdBit | output | 1 | Right registered read data (0 = owned) |

## Verification
Two pairs of events can land in the same cycle. One is two requests for the same free token. The other is one port reading a token while the other port releases it. The bench drives both ports in a single cycle. For simultaneous requests, it expects the left port to own the token and the right port to take over as soon as the left releases. For the read-during-release case, it expects the read to return the pre-release value (1 for the waiting reader). A follow-up read then shows the hand-over (0).

// File: rtl/semtok_pkg.sv
package semtok_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NUM_PORTS = 2;
  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;

  // strobes from control to datapath, one set per port
  typedef struct packed {
    logic req;   // write of 0
    logic rel;   // write of 1
    logic rd;    // read access
  } portStrobe_t;

  function automatic owner_e portOwner(input int p);
    return (p == PORT_LEFT) ? OWN_LEFT : OWN_RIGHT;
  endfunction

endpackage

// File: rtl/semtok_ctrl.sv
module semtok_ctrl
  import semtok_pkg::*;
(
  input  logic        sel   [NUM_PORTS],
  input  logic        wrEn  [NUM_PORTS],
  input  logic        wrBit [NUM_PORTS],
  output portStrobe_t strb  [NUM_PORTS]
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      strb[p].req = sel[p] &&  wrEn[p] && !wrBit[p];
      strb[p].rel = sel[p] &&  wrEn[p] &&  wrBit[p];
      strb[p].rd  = sel[p] && !wrEn[p];
    end
  end

endmodule

// File: rtl/semtok_cell.sv
module semtok_cell
  import semtok_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqL,
  input  logic   reqR,
  input  logic   relL,
  input  logic   relR,
  output owner_e owner
);

  logic   pendL, pendR;
  owner_e ownerNxt;
  logic   pendLNxt, pendRNxt;
  logic   keepL, keepR, wantL, wantR, freed;

  always_comb begin
    keepL = pendL && !relL;
    keepR = pendR && !relR;
    wantL = reqL || keepL;
    wantR = reqR || keepR;
    freed = (owner == OWN_NONE) ||
            (relL && owner == OWN_LEFT) ||
            (relR && owner == OWN_RIGHT);
    if (freed) begin
      if (wantL)      ownerNxt = OWN_LEFT;
      else if (wantR) ownerNxt = OWN_RIGHT;
      else            ownerNxt = OWN_NONE;
      pendLNxt = wantL && (ownerNxt != OWN_LEFT);
      pendRNxt = wantR && (ownerNxt != OWN_RIGHT);
    end else begin
      ownerNxt = owner;
      pendLNxt = keepL || (owner == OWN_RIGHT && reqL);
      pendRNxt = keepR || (owner == OWN_LEFT  && reqR);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner <= OWN_NONE;
      pendL <= 1'b0;
      pendR <= 1'b0;
    end else begin
      owner <= ownerNxt;
      pendL <= pendLNxt;
      pendR <= pendRNxt;
    end
  end

  // R4: free token requested by the left port goes to the left port
  a_r4_free_grant: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE && reqL) |=> (owner == OWN_LEFT));

  // R5: request against the other port's token waits
  a_r5_wait: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_RIGHT && reqL && !relR) |=> (owner == OWN_RIGHT && pendL));

  // R6: simultaneous request on a free token
  a_r6_tie_left: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE && reqL && reqR) |=> (owner == OWN_LEFT && pendR));

  // R7: release hands over to the waiting port
  a_r7_handoff: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_LEFT && relL && pendR) |=> (owner == OWN_RIGHT && !pendR));

  // R8: release by a non-owner leaves ownership and drops its wait
  a_r8_nonowner: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_LEFT && relR && !relL) |=> (owner == OWN_LEFT && !pendR));

  // R5: an owner never also waits for its own token
  always_ff @(posedge clk) begin
    if (rstN) begin
      a_r5_owner_not_pending: assert (!(owner == OWN_LEFT && pendL) &&
                                      !(owner == OWN_RIGHT && pendR));
    end
  end

endmodule

// File: rtl/semtok_dp.sv
module semtok_dp
  import semtok_pkg::*;
#(
  parameter int NTOK  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strb  [NUM_PORTS],
  input  logic [IDX_W-1:0] idx   [NUM_PORTS],
  output logic             rdBit [NUM_PORTS]
);

  owner_e owners [NTOK];

  for (genvar t = 0; t < NTOK; t++) begin : g_tok
    logic hitL, hitR;
    assign hitL = (idx[PORT_LEFT]  == IDX_W'(t));
    assign hitR = (idx[PORT_RIGHT] == IDX_W'(t));
    semtok_cell cell_i (
      .clk   (clk),
      .rstN  (rstN),
      .reqL  (strb[PORT_LEFT].req  && hitL),
      .reqR  (strb[PORT_RIGHT].req && hitR),
      .relL  (strb[PORT_LEFT].rel  && hitL),
      .relR  (strb[PORT_RIGHT].rel && hitR),
      .owner (owners[t])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    owner_e selOwner;
    always_comb begin
      selOwner = OWN_NONE;
      for (int t = 0; t < NTOK; t++)
        if (idx[p] == IDX_W'(t)) selOwner = owners[t];
    end
    always_ff @(posedge clk) begin
      if (!rstN)          rdBit[p] <= 1'b1;
      else if (strb[p].rd) rdBit[p] <= (selOwner != portOwner(p));
    end

    // R2/R3: read data only moves on a read access of that port
    a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strb[p].rd |=> $stable(rdBit[p]));
  end

  // R2: the two ports never both read 0 for one token in the same cycle
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (strb[PORT_LEFT].rd && strb[PORT_RIGHT].rd && idx[PORT_LEFT] == idx[PORT_RIGHT])
      |=> !(rdBit[PORT_LEFT] == 1'b0 && rdBit[PORT_RIGHT] == 1'b0));

endmodule

// File: rtl/semtok_bank.sv
module semtok_bank
  import semtok_pkg::*;
#(
  parameter int NTOK  = 8,
  parameter int IDX_W = (NTOK > 1) ? $clog2(NTOK) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lSel,
  input  logic             lWrEn,
  input  logic [IDX_W-1:0] lIdx,
  input  logic             lWrBit,
  output logic             lRdBit,
  input  logic             rSel,
  input  logic             rWrEn,
  input  logic [IDX_W-1:0] rIdx,
  input  logic             rWrBit,
  output logic             rRdBit
);

  logic             selA   [NUM_PORTS];
  logic             wrEnA  [NUM_PORTS];
  logic             wrBitA [NUM_PORTS];
  logic [IDX_W-1:0] idxA   [NUM_PORTS];
  logic             rdA    [NUM_PORTS];
  portStrobe_t      strb   [NUM_PORTS];

  assign selA[PORT_LEFT]    = lSel;
  assign selA[PORT_RIGHT]   = rSel;
  assign wrEnA[PORT_LEFT]   = lWrEn;
  assign wrEnA[PORT_RIGHT]  = rWrEn;
  assign wrBitA[PORT_LEFT]  = lWrBit;
  assign wrBitA[PORT_RIGHT] = rWrBit;
  assign idxA[PORT_LEFT]    = lIdx;
  assign idxA[PORT_RIGHT]   = rIdx;
  assign lRdBit = rdA[PORT_LEFT];
  assign rRdBit = rdA[PORT_RIGHT];

  semtok_ctrl ctrl_i (
    .sel   (selA),
    .wrEn  (wrEnA),
    .wrBit (wrBitA),
    .strb  (strb)
  );

  semtok_dp #(.NTOK(NTOK), .IDX_W(IDX_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .idx   (idxA),
    .rdBit (rdA)
  );

  // R3: a deselected port's read data does not move
  a_r3_idle_left: assert property (@(posedge clk) disable iff (!rstN)
    !lSel |=> $stable(lRdBit));

endmodule

// File: tb/semtok_bank_tb_top.sv
module semtok_bank_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lSel = 0, lWrEn = 0, lWrBit = 0;
  logic       rSel = 0, rWrEn = 0, rWrBit = 0;
  logic [2:0] lIdx = 0, rIdx = 0;
  logic       lRdBit, rRdBit;
  int         nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  semtok_bank dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle on both ports; sel=0 means idle
  task automatic cyc(input logic ls, input logic lw, input int li, input logic lb,
                     input logic rs, input logic rw, input int ri, input logic rb);
    @(negedge clk);
    lSel = ls; lWrEn = lw; lIdx = 3'(li); lWrBit = lb;
    rSel = rs; rWrEn = rw; rIdx = 3'(ri); rWrBit = rb;
    @(posedge clk); #1;
    lSel = 0; rSel = 0;
  endtask

  // read token t on both ports, check both results
  task automatic rdBoth(input int t, input logic expL, input logic expR, input string req);
    cyc(1, 0, t, 0, 1, 0, t, 0);
    chk({req, " left"}, lRdBit, expL);
    chk({req, " right"}, rRdBit, expR);
  endtask

  task automatic t_reset;
    for (int t = 0; t < 8; t++) rdBoth(t, 1, 1, "R1");
  endtask

  task automatic t_grant;
    cyc(1, 1, 3, 0, 0, 0, 0, 0);          // left requests token 3
    rdBoth(3, 0, 1, "R4");
    rdBoth(2, 1, 1, "R9");                 // neighbour untouched
    cyc(1, 1, 3, 0, 0, 0, 0, 0);           // owner requests again
    rdBoth(3, 0, 1, "R9");
  endtask

  task automatic t_wait_handoff;
    cyc(0, 0, 0, 0, 1, 1, 3, 0);           // right requests held token 3
    rdBoth(3, 0, 1, "R5");
    cyc(1, 1, 3, 1, 0, 0, 0, 0);           // left releases
    rdBoth(3, 1, 0, "R7");
  endtask

  task automatic t_nonowner;
    cyc(1, 1, 3, 1, 0, 0, 0, 0);           // left releases right's token
    rdBoth(3, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, 1, 3, 1);
    rdBoth(3, 1, 1, "R7");
    cyc(1, 1, 5, 0, 0, 0, 0, 0);           // left owns 5
    cyc(0, 0, 0, 0, 1, 1, 5, 0);           // right waits
    cyc(0, 0, 0, 0, 1, 1, 5, 1);           // right withdraws
    cyc(1, 1, 5, 1, 0, 0, 0, 0);           // left releases
    rdBoth(5, 1, 1, "R8");
  endtask

  task automatic t_tie;
    cyc(1, 1, 6, 0, 1, 1, 6, 0);
    rdBoth(6, 0, 1, "R6");
    cyc(1, 1, 6, 1, 0, 0, 0, 0);
    rdBoth(6, 1, 0, "R6");
    cyc(0, 0, 0, 0, 1, 1, 6, 1);
    rdBoth(6, 1, 1, "R6");
  endtask

  task automatic t_deselect;
    cyc(1, 1, 1, 0, 0, 0, 0, 0);           // left owns 1
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 left owns", lRdBit, 0);
    // deselected write of 0 to token 0 and deselected read of token 2
    @(negedge clk);
    lSel = 0; lWrEn = 0; lIdx = 3'd2;
    rSel = 0; rWrEn = 1; rIdx = 3'd0; rWrBit = 0;
    @(posedge clk); #1;
    chk("R3 read data held", lRdBit, 0);
    rdBoth(0, 1, 1, "R3");
    cyc(1, 1, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_read_during_release;
    cyc(1, 1, 4, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, 4, 0);           // right waits
    cyc(1, 1, 4, 1, 1, 0, 4, 0);           // left releases, right reads
    chk("R2 pre-state read", rRdBit, 1);
    rdBoth(4, 1, 0, "R7");
    cyc(0, 0, 0, 0, 1, 1, 4, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 left idle", lRdBit, 1);
    chk("R1 right idle", rRdBit, 1);
    t_reset();
    t_grant();
    t_wait_handoff();
    t_nonowner();
    t_tie();
    t_deselect();
    t_read_during_release();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #20000;
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule